// File: doc/BRIEF.md
# Low-Frequency Carrier Transmit Controller

This block produces the square-wave carrier for an inductive reader in the 134 kHz band. The carrier powers the tag and carries data to it. The block divides its master clock by a parameterised ratio, 128 by default. With a 17.1776 MHz master clock this gives a carrier near 134.2 kHz. The carrier drives two gate-control outputs for an external half bridge: one for the P-channel high-side switch and one for the N-channel low-side switch. Each output has its own output enable, so the pad can model an open drain.

An asynchronous active-low enable input chooses the mode. While the enable is low the block sends, and both gate outputs follow one composite carrier. While the enable is high the block is in receive mode and the bridge is parked: the high-side control is driven high and the low-side control is released to high impedance.

The enable passes through a two-flop synchroniser. Entry and exit latencies are fixed relative to that synchroniser. Every burst starts with the same carrier phase, because the divider is held at zero outside sending.

Top module: `lf_carrier_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are in the parked state: `hs_gate`=1, `hs_oe`=1, `ls_oe`=0, `ls_gate`=0.
- R2: When the synchronised enable reads high (receive mode), the outputs stay in the parked state of R1 for every cycle.
- R3: Send mode is entered on the second clock edge after `tx_en_n` goes low, through the two-flop synchroniser. The first falling edge of `hs_gate` follows 64 clock cycles after that entry. Seen from the first clock edge after the input change, `hs_gate` is first low after edge 66.
- R4: While sending, the carrier period is DIV = 128 clock cycles, measured from one falling edge of `hs_gate` to the next.
- R5: Within each period, `hs_gate` is high for 64 cycles (the carrier starts high at entry) and then low for 64 cycles.
- R6: On the second clock edge after `tx_en_n` goes high, the outputs return to the parked state. This is within one cycle of the synchronised edge, at any carrier phase.
- R7: While sending, `ls_oe`=1 and `ls_gate` equals `hs_gate` on every cycle.
- R8: Each new burst restarts the divider at phase zero. The entry latency of R3 is the same after any exit, including a receive gap of only a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Asynchronous active-low send enable (high = receive) |
| hs_gate | output | 1 | High-side P-channel gate control (composite carrier) |
| hs_oe | output | 1 | High-side output enable (always driven) |
| ls_gate | output | 1 | Low-side N-channel gate control (composite carrier) |
| ls_oe | output | 1 | Low-side output enable, released in receive mode |

## Verification
A change on `tx_en_n` takes effect on the second rising edge after it, through the synchroniser. After that:
- On exit, the park state is due at once, so it is visible at the second falling edge.
- On entry, the first low carrier level is due 64 edges later, at the 66th falling edge.
- After the first fall, the carrier toggles every 64 edges.

The bench drives inputs on falling edges and counts falling edges until each output transition. It compares those counts with 66, 64, 64, 128 and 2. A behavioural model rebuilds the synchronised mode from a two-entry queue of input samples and a burst-phase integer. Every falling edge compares all four outputs against that model.

// File: rtl/lf_tx_pkg.sv
package lf_tx_pkg;

  typedef enum logic {
    MODE_RECV = 1'b0,
    MODE_SEND = 1'b1
  } tx_mode_e;

  // Carrier level for a given phase: high in the first half of the period.
  function automatic logic carrier_level(input int unsigned phase,
                                         input int unsigned period);
    return (phase < (period / 2));
  endfunction

  // Phase that follows the given one, wrapping at the period.
  function automatic int unsigned next_phase(input int unsigned phase,
                                             input int unsigned period);
    return (phase >= period - 1) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/lf_tx_sync.sv
module lf_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/lf_tx_phase.sv
module lf_tx_phase #(
  parameter int DIV   = 128,
  parameter int CNT_W = $clog2(DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send,
  output logic [CNT_W-1:0] phase,
  output logic             burst_start
);
  import lf_tx_pkg::*;

  logic send_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      send_d <= 1'b0;
    end else begin
      send_d <= send;
      if (!send) phase <= '0;
      else       phase <= CNT_W'(next_phase(32'(phase), DIV));
    end
  end

  assign burst_start = send && !send_d;

  // R8
  entry_phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (phase == '0));

  // R4
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send && phase == CNT_W'(DIV-1)) |=> (phase == '0));

endmodule

// File: rtl/lf_tx_drive.sv
module lf_tx_drive #(
  parameter int DIV   = 128,
  parameter int CNT_W = $clog2(DIV)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  lf_tx_pkg::tx_mode_e       mode,
  input  logic [CNT_W-1:0]          phase,
  output logic                      hs_gate,
  output logic                      hs_oe,
  output logic                      ls_gate,
  output logic                      ls_oe
);
  import lf_tx_pkg::*;

  logic carrier;

  assign carrier = carrier_level(32'(phase), DIV);

  always_comb begin
    hs_oe = 1'b1;
    if (mode == MODE_SEND) begin
      hs_gate = carrier;
      ls_gate = carrier;
      ls_oe   = 1'b1;
    end else begin
      hs_gate = 1'b1;
      ls_gate = 1'b0;
      ls_oe   = 1'b0;
    end
  end

  // R7
  legs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_oe |-> (ls_gate == hs_gate));

  // R5
  fall_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_gate) && ls_oe) |-> (phase == CNT_W'(DIV/2)));

endmodule

// File: rtl/lf_carrier_tx.sv
module lf_carrier_tx #(
  parameter int DIV         = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_n,
  output logic hs_gate,
  output logic hs_oe,
  output logic ls_gate,
  output logic ls_oe
);
  import lf_tx_pkg::*;

  localparam int CNT_W = $clog2(DIV);

  logic             en_n_sync;
  tx_mode_e         mode;
  logic             send;
  logic [CNT_W-1:0] phase;
  logic             burst_start;

  lf_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (tx_en_n),
    .dout  (en_n_sync)
  );

  assign mode = en_n_sync ? MODE_RECV : MODE_SEND;
  assign send = (mode == MODE_SEND);

  lf_tx_phase #(.DIV(DIV), .CNT_W(CNT_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .send        (send),
    .phase       (phase),
    .burst_start (burst_start)
  );

  lf_tx_drive #(.DIV(DIV), .CNT_W(CNT_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .phase   (phase),
    .hs_gate (hs_gate),
    .hs_oe   (hs_oe),
    .ls_gate (ls_gate),
    .ls_oe   (ls_oe)
  );

  // R2
  parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_sync |-> (hs_gate && hs_oe && !ls_oe));

  // R6
  exit_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_n_sync) |-> (!ls_oe && hs_gate));

  // R3
  entry_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (hs_gate && ls_oe));

endmodule

// File: tb/lf_carrier_tx_tb.sv
module lf_carrier_tx_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en_n = 1'b1;
  logic hs_gate, hs_oe, ls_gate, ls_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lf_carrier_tx u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en_n (tx_en_n),
    .hs_gate (hs_gate),
    .hs_oe   (hs_oe),
    .ls_gate (ls_gate),
    .ls_oe   (ls_oe)
  );

  // Behavioural reference: queue of recent input samples plus burst phase.
  logic samples[$];
  int   ref_t = 0;
  bit   ref_send = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      samples = {1'b1, 1'b1};
      ref_t = 0;
      ref_send = 0;
    end else begin
      samples.push_back(tx_en_n);
      void'(samples.pop_front());
      if (samples[0] == 1'b0) begin
        ref_t = ref_send ? (ref_t + 1) % 128 : 0;
        ref_send = 1;
      end else begin
        ref_t = 0;
        ref_send = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle compare against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic eh, el, eo;
      eh = ref_send ? (ref_t < 64) : 1'b1;
      el = ref_send ? (ref_t < 64) : 1'b0;
      eo = ref_send;
      if (ref_send)  // R7 / R5 while sending
        check({hs_gate, hs_oe, ls_gate, ls_oe} === {eh, 1'b1, el, eo}, "R7",
              {hs_gate, hs_oe, ls_gate, ls_oe}, {eh, 1'b1, el, eo});
      else           // R2 parked in receive
        check({hs_gate, hs_oe, ls_oe} === {1'b1, 1'b1, 1'b0}, "R2",
              {hs_gate, hs_oe, ls_oe}, 3'b110);
    end
  end

  task automatic wait_hs(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (hs_gate !== lvl && n < 1000);
  endtask

  task automatic wait_park(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ls_oe !== 1'b0 && n < 1000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({hs_gate, hs_oe, ls_gate, ls_oe} === 4'b1100, "R1",
          {hs_gate, hs_oe, ls_gate, ls_oe}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    check({hs_gate, hs_oe, ls_gate, ls_oe} === 4'b1100, "R1",
          {hs_gate, hs_oe, ls_gate, ls_oe}, 4'b1100);
    repeat (20) @(negedge clk);

    // Burst 1: entry latency, duty and period
    tx_en_n = 1'b0;
    wait_hs(1'b0, n);
    check(n == 66, "R3", n, 66);
    wait_hs(1'b1, n);
    check(n == 64, "R5 low", n, 64);
    wait_hs(1'b0, n);
    check(n == 64, "R5 high", n, 64);
    begin
      int a, b;
      wait_hs(1'b1, a);
      wait_hs(1'b0, b);
      check(a + b == 128, "R4", a + b, 128);
    end
    // exit while carrier is low
    repeat (10) @(negedge clk);
    tx_en_n = 1'b1;
    wait_park(n);
    check(n == 2, "R6 low phase", n, 2);
    check(hs_gate === 1'b1, "R6 hs", hs_gate, 1);
    repeat (37) @(negedge clk);

    // Burst 2: same phase after a long gap
    tx_en_n = 1'b0;
    wait_hs(1'b0, n);
    check(n == 66, "R8 second burst", n, 66);
    // exit while carrier is high
    wait_hs(1'b1, n);
    repeat (5) @(negedge clk);
    tx_en_n = 1'b1;
    wait_park(n);
    check(n == 2, "R6 high phase", n, 2);

    // Burst 3 after a 3-cycle receive gap
    repeat (3) @(negedge clk);
    tx_en_n = 1'b0;
    wait_hs(1'b0, n);
    check(n == 66, "R8 short gap", n, 66);
    check(ls_oe === 1'b1 && ls_gate === 1'b0, "R7", {ls_oe, ls_gate}, 2'b10);
    tx_en_n = 1'b1;
    wait_park(n);
    check(n == 2, "R6 third", n, 2);

    // Long receive period: stays parked
    repeat (300) @(negedge clk);
    check({hs_gate, hs_oe, ls_oe} === 3'b110, "R2 idle", {hs_gate, hs_oe, ls_oe}, 3'b110);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule